// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the refresh side of an asynchronous DRAM controller. After reset it stays silent for a power-up pause. It then asks for the bus for a fixed number of warm-up refresh cycles. Once the last of these has finished, it raises an init-done flag that opens the memory to normal accesses. From then on, an interval timer derived from the refresh period and the row count produces evenly spaced refresh requests. A saturating counter holds any requests that are still waiting.

When the access controller grants the bus, the block runs one CAS-before-RAS refresh on the shared strobes. CAS falls first, RAS follows, CAS is released while RAS is still low, and then a precharge gap follows. Write enable is held high throughout, so no row address and no data are involved. A completion pulse closes each cycle. An urgent flag tells the access controller that the pending store is full and that the next grant must go to refresh. All timing is expressed in clock cycles through parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: For the first PWRUP_CYC clock edges after reset is released, req_o stays low and ras_n_o and cas_n_o stay high. During reset all three are in that same state and init_done_o is low.
- R2: Exactly INIT_REFRESHES refresh cycles run before init_done_o rises. It rises after the completion of the last of them, and it then stays high until reset.
- R3: In every refresh cycle cas_n_o falls first, and ras_n_o falls exactly CAS_SU_CYC cycles later while cas_n_o is still low.
- R4: cas_n_o stays low for exactly CAS_HOLD_CYC cycles after ras_n_o falls, then rises while ras_n_o is still low.
- R5: ras_n_o is low for exactly RAS_LOW_CYC cycles per refresh. Between two refreshes it is high for at least RAS_PRE_CYC + 1 cycles.
- R6: we_n_o is high at every falling edge of ras_n_o and at all other times.
- R7: A refresh starts only at a clock edge where req_o and grant_i are both high and no refresh is in progress. done_o pulses for exactly one cycle per refresh, after its precharge.
- R8: After init, one refresh request is produced every PERIOD_CYC/ROWS cycles.
- R9: Pending requests accumulate up to PEND_MAX, and further requests are dropped. urgent_o is high exactly while the store is full. A grant after saturation drains PEND_MAX refreshes, plus at most one that arrives during the drain.
- R10: After init, req_o is high while at least one refresh is pending, and low once all are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Access controller hands the strobes to this block |
| req_o | output | 1 | A refresh is wanted |
| urgent_o | output | 1 | Pending store full; grant must be next |
| init_done_o | output | 1 | Pause and warm-up refreshes complete |
| done_o | output | 1 | One-cycle pulse at the end of each refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
On every cycle, the embedded properties check the following: CAS is low when RAS falls, CAS rises only while RAS is low, a refresh begins only on a grant, the pending store stays full under extra requests, and init-done never drops. They also check that the strobes and the request stay quiet during the pause. The exact cycle lengths of the setup, hold, active and precharge phases are checked only by the bench's edge monitor, which measures them on every refresh. The same applies to the number of warm-up refreshes, the average rate over a scaled period, and the size of the drained burst after saturation.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_CSU  = 2'd1,
      S_ACT  = 2'd2,
      S_PRE  = 2'd3
   } rfsh_state_t;
endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
   parameter int INTERVAL_CYC = 781
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   generate
      if (INTERVAL_CYC < 1) begin : g_bad
         $error("INTERVAL_CYC must be at least 1");
      end
      if (INTERVAL_CYC == 1) begin : g_every
         assign tick_o = en_i;
      end else begin : g_count
         localparam int TW = $clog2(INTERVAL_CYC);
         localparam logic [TW-1:0] RELOAD = TW'(INTERVAL_CYC - 1);
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt_q <= RELOAD;
            else if (en_i) begin
               if (cnt_q == '0)          cnt_q <= RELOAD;
               else                      cnt_q <= cnt_q - 1'b1;
            end
         end
         assign tick_o = en_i && (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
   parameter int PEND_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic take_i,
   output logic nonzero_o,
   output logic urgent_o
);
   localparam int PW = $clog2(PEND_MAX + 1);
   localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

   generate
      if (PEND_MAX < 1) begin : g_bad
         $error("PEND_MAX must be at least 1");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic          add;

   assign add = tick_i && ((cnt_q != FULL) || take_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (add && !take_i)  cnt_q <= cnt_q + 1'b1;
      else if (!add && take_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign nonzero_o = (cnt_q != '0);
   assign urgent_o  = (cnt_q == FULL);

   a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL && tick_i && !take_i) |=> (cnt_q == FULL));
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> (cnt_q != '0));
endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
   import rfsh_pkg::*;
#(
   parameter int CAS_SU_CYC   = 1,
   parameter int RAS_LOW_CYC  = 3,
   parameter int CAS_HOLD_CYC = 1,
   parameter int RAS_PRE_CYC  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic idle_o,
   output logic done_o,
   output logic ras_n_o,
   output logic cas_n_o
);
   localparam int CW = $clog2(CAS_SU_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1);
   localparam logic [CW-1:0] SU_LD   = CW'(CAS_SU_CYC - 1);
   localparam logic [CW-1:0] ACT_LD  = CW'(RAS_LOW_CYC - 1);
   localparam logic [CW-1:0] PRE_LD  = CW'(RAS_PRE_CYC - 1);
   localparam logic [CW-1:0] CAS_REL = CW'(RAS_LOW_CYC - CAS_HOLD_CYC);

   generate
      if (CAS_SU_CYC < 1 || RAS_PRE_CYC < 1) begin : g_bad_phase
         $error("setup and precharge phases need at least one cycle");
      end
      if (CAS_HOLD_CYC < 1 || CAS_HOLD_CYC >= RAS_LOW_CYC) begin : g_bad_hold
         $error("CAS hold must be shorter than the RAS low phase");
      end
   endgenerate

   rfsh_state_t   st_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: if (start_i) begin
               st_q  <= S_CSU;
               cnt_q <= SU_LD;
            end
            S_CSU: if (cnt_q == '0) begin
               st_q  <= S_ACT;
               cnt_q <= ACT_LD;
            end else cnt_q <= cnt_q - 1'b1;
            S_ACT: if (cnt_q == '0) begin
               st_q  <= S_PRE;
               cnt_q <= PRE_LD;
            end else cnt_q <= cnt_q - 1'b1;
            S_PRE: if (cnt_q == '0) begin
               st_q   <= S_IDLE;
               done_q <= 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign idle_o  = (st_q == S_IDLE);
   assign done_o  = done_q;
   assign ras_n_o = (st_q != S_ACT);
   assign cas_n_o = !((st_q == S_CSU) || (st_q == S_ACT && cnt_q >= CAS_REL));

   a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));
   a_r4_cas_release_ras_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n_o) |-> !ras_n_o);
   a_r7_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CSU && $past(st_q) == S_IDLE) |-> $past(start_i));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int PWRUP_CYC      = 10000,
   parameter int PERIOD_CYC     = 3200000,
   parameter int ROWS           = 4096,
   parameter int INIT_REFRESHES = 8,
   parameter int PEND_MAX       = 8,
   parameter int CAS_SU_CYC     = 1,
   parameter int RAS_LOW_CYC    = 3,
   parameter int CAS_HOLD_CYC   = 1,
   parameter int RAS_PRE_CYC    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_i,
   output logic req_o,
   output logic urgent_o,
   output logic init_done_o,
   output logic done_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o
);
   localparam int INTERVAL_CYC = PERIOD_CYC / ROWS;
   localparam int PAW = $clog2(PWRUP_CYC + 1);
   localparam int WW  = $clog2(INIT_REFRESHES + 1);

   generate
      if (PWRUP_CYC < 1 || INIT_REFRESHES < 1) begin : g_bad_init
         $error("pause and warm-up count must be at least 1");
      end
      if (INTERVAL_CYC <= CAS_SU_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1) begin : g_bad_rate
         $error("refresh interval shorter than one refresh cycle");
      end
   endgenerate

   logic [PAW-1:0] pause_q;
   logic [WW-1:0]  warm_q;
   logic           init_done_q;
   logic           pause_over, seq_idle, seq_done, start;
   logic           tick, pend_nz;

   assign pause_over = (pause_q == '0);
   assign req_o  = pause_over && ((warm_q != '0) || (init_done_q && pend_nz));
   assign start  = req_o && grant_i && seq_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pause_q     <= PAW'(PWRUP_CYC);
         warm_q      <= WW'(INIT_REFRESHES);
         init_done_q <= 1'b0;
      end else begin
         if (!pause_over) pause_q <= pause_q - 1'b1;
         if (start && warm_q != '0) warm_q <= warm_q - 1'b1;
         if (seq_done && warm_q == '0) init_done_q <= 1'b1;
      end
   end

   rfsh_tick_gen #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .en_i(init_done_q), .tick_o(tick));

   rfsh_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .take_i(start && init_done_q), .nonzero_o(pend_nz), .urgent_o(urgent_o));

   rfsh_cbr_seq #(
      .CAS_SU_CYC(CAS_SU_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
      .CAS_HOLD_CYC(CAS_HOLD_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .idle_o(seq_idle),
      .done_o(seq_done), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o));

   assign init_done_o = init_done_q;
   assign done_o      = seq_done;
   assign we_n_o      = 1'b1;

   a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_over |-> (!req_o && ras_n_o && cas_n_o));
   a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |=> init_done_o);
   a_r2_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done_o) |-> $past(done_o));
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
   localparam int PWRUP = 300, PERIOD = 6400, ROWS = 32, INIT = 8, PMAX = 8;
   localparam int CSU = 1, RLOW = 4, HOLD = 2, PRE = 3;
   localparam int IVL = PERIOD / ROWS;

   logic clk = 0, rst_n = 0, grant = 0;
   logic req, urgent, idone, done, ras_n, cas_n, we_n;

   dram_refresh_sched #(
      .PWRUP_CYC(PWRUP), .PERIOD_CYC(PERIOD), .ROWS(ROWS), .INIT_REFRESHES(INIT),
      .PEND_MAX(PMAX), .CAS_SU_CYC(CSU), .RAS_LOW_CYC(RLOW),
      .CAS_HOLD_CYC(HOLD), .RAS_PRE_CYC(PRE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .grant_i(grant), .req_o(req), .urgent_o(urgent),
      .init_done_o(idone), .done_o(done), .ras_n_o(ras_n), .cas_n_o(cas_n),
      .we_n_o(we_n));

   always #10 clk = ~clk;

   int checks = 0, fails = 0, cycles = 0;
   int n_ref = 0, n_done = 0, cas_run = 0, ras_low_run = 0, ras_high_run = 0;
   bit prev_ras = 1, prev_cas = 1, seen_ref = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Edge monitor: measures every refresh's phases (R3, R4, R5, R6, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         cycles++;
         if (done) n_done++;
         if (prev_ras && !ras_n) begin
            n_ref++;
            chk(!cas_n && cas_run == CSU, "R3 cas lead", cas_run, CSU);
            chk(we_n, "R6 we high at ras fall", we_n, 1);
            if (seen_ref) chk(ras_high_run >= PRE + 1, "R5 precharge", ras_high_run, PRE + 1);
            seen_ref = 1;
         end
         if (!prev_cas && cas_n && !prev_ras)
            chk(!ras_n && ras_low_run == HOLD, "R4 cas hold", ras_low_run, HOLD);
         if (!prev_ras && ras_n)
            chk(ras_low_run == RLOW, "R5 ras low", ras_low_run, RLOW);
         cas_run      = cas_n ? 0 : cas_run + 1;
         ras_low_run  = ras_n ? 0 : ras_low_run + 1;
         ras_high_run = ras_n ? ras_high_run + 1 : 0;
         prev_ras = ras_n;
         prev_cas = cas_n;
      end
   end

   always @(negedge clk) begin
      if (cycles > 150000) begin
         chk(0, "watchdog", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      int quiet_bad, base, got, t;
      grant = 1;
      repeat (3) @(negedge clk);
      chk(!req && ras_n && cas_n && !idone, "R1 reset state", {req, ras_n, cas_n, idone}, 3'b011 << 0);
      @(negedge clk) rst_n = 1;
      quiet_bad = 0;
      for (int i = 1; i < PWRUP; i++) begin
         @(negedge clk);
         if (req || !ras_n || !cas_n) quiet_bad++;
      end
      chk(quiet_bad == 0, "R1 silent pause", quiet_bad, 0);
      t = 0;
      while (!idone && t < 2000) begin @(negedge clk); t++; end
      chk(idone, "R2 init done reached", idone, 1);
      chk(n_ref == INIT, "R2 warm-up count", n_ref, INIT);
      chk(n_done == INIT, "R7 done pulses during warm-up", n_done, INIT);

      // R8: average rate over 20 intervals
      base = n_ref;
      repeat (20 * IVL) @(negedge clk);
      got = n_ref - base;
      chk(got >= 19 && got <= 21, "R8 refresh rate", got, 20);
      chk(idone, "R2 init done sticky", idone, 1);

      // R9/R10: withhold grant, let requests pile up
      grant = 0;
      repeat (3 * IVL) @(negedge clk);
      base = n_ref;
      chk(req, "R10 req while pending", req, 1);
      chk(!urgent, "R9 not urgent below limit", urgent, 0);
      repeat (10 * IVL) @(negedge clk);
      chk(urgent, "R9 urgent at limit", urgent, 1);
      chk(n_ref == base, "R7 no refresh without grant", n_ref - base, 0);
      grant = 1;
      t = 0;
      while (req && t < 400) begin @(negedge clk); t++; end
      repeat (12) @(negedge clk);
      got = n_ref - base;
      chk(got == PMAX || got == PMAX + 1, "R9 drained burst size", got, PMAX);
      chk(!urgent, "R9 urgent cleared", urgent, 0);
      chk(!req, "R10 req low when drained", req, 0);
      chk(n_done == n_ref, "R7 one done per refresh", n_done, n_ref);
      chk(we_n, "R6 we high idle", we_n, 1);
      finish_run();
   end
endmodule